// File: doc/BRIEF.md
# External Interruption Source Selector

This block keeps track of the external interruption conditions waiting for one processor. When a request arrives and the processor is enabled, it picks the single most urgent condition that is not masked and presents it. Latched conditions come in as one-cycle set pulses: an interrupt key, an external call with the address of the calling CPU, an interval timer and a service signal with a parameter word. Malfunction alerts and emergency signals come in as vectors with one bit per source CPU, and each of these two sources also has a summary pending flag. Two conditions are not latched. They are compared every cycle: the time-of-day value against the clock comparator, and the sign of the CPU timer.

Each successful selection raises a one-cycle `take` strobe. With it come three fields: a 16-bit interruption code, a 16-bit originating-address field and a parameter word. In the same clock edge the block clears only the condition it consumed. The result has no back-pressure. It is a registered strobe with no ready, and the consumer must capture the three fields in the cycle `take` is high. The fields keep their values until the next take. Saving or loading the program status word and writing to memory belong to the consumer.

Top module: `ext_int_selector`

## Requirements
- R1: After reset, `take` is 0, all three result fields are 0 and no condition is pending, so a request taken with nothing pending gives no strobe.
- R2: Among the conditions that are pending and unmasked, the winner is chosen by fixed priority, from highest to lowest: interrupt key (code 0x0040), malfunction alert (0x1200), emergency signal (0x1201), external call (0x1202), clock comparator (0x1004), CPU timer (0x1005), interval timer (0x0080), service signal (0x2401).
- R3: A request consumes at most one condition. Every other pending condition stays pending for later requests.
- R4: For malfunction alert and emergency signal, the lowest CPU number whose bit is set wins. That bit is cleared and its number appears in the originating-address field. Repeated requests drain the vector in ascending order.
- R5: If a vector source wins while its summary flag is set and its vector is empty, the flag is cleared and that request gives no strobe.
- R6: The clock-comparator condition holds only while the time-of-day value is strictly greater than the comparator. A take does not clear it.
- R7: The CPU-timer condition holds while the timer, read as a two's-complement number, is negative.
- R8: The originating-address field carries the calling CPU address for external call and the CPU number for the two vector sources. It is 0 for every other source. The parameter word is 0 for every source except the service signal.
- R9: For a service signal latched with the address flag set, prefixing is applied at the take. The page-number part is the bits at and above `PFX_LSB`, which is 13 by default. If the page number is zero, it is replaced by the prefix page. If it equals the prefix page, it is replaced by zero. Otherwise the value passes unchanged. Without the address flag, the parameter passes unchanged. The take then clears the parameter and the pending flag.
- R10: A source whose bit in `src_en` is 0 never wins, even when pending, and stays pending. Bit order follows the priority in R2: bit 0 is the key and bit 7 is the service signal.
- R11: While `ext_en` is 0, a request gives no strobe and consumes nothing.
- R12: `take` rises in the cycle after the edge that samples the request and lasts one cycle per request. If a set pulse and a take of the same source fall in the same cycle, the set wins and the condition stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_en | input | 1 | Global enable for external interruptions |
| src_en | input | 8 | Per-source masks, bit order as in R2 |
| eval_req | input | 1 | Request to select one condition |
| key_set | input | 1 | Interrupt-key set pulse |
| malf_set | input | 1 | Malfunction-alert set pulse |
| malf_vec | input | NCPU | CPU bits OR-ed in on `malf_set` |
| emer_set | input | 1 | Emergency-signal set pulse |
| emer_vec | input | NCPU | CPU bits OR-ed in on `emer_set` |
| xcall_set | input | 1 | External-call set pulse |
| xcall_cpu | input | 16 | Calling CPU address, latched on `xcall_set` |
| itmr_set | input | 1 | Interval-timer set pulse |
| svc_set | input | 1 | Service-signal set pulse |
| svc_parm | input | PARM_W | Service parameter, latched on `svc_set` |
| svc_is_addr | input | 1 | Marks the service parameter as a storage address |
| prefix | input | PARM_W | Prefix value used for R9 |
| tod | input | TOD_W | Time-of-day value |
| clkc | input | TOD_W | Clock comparator |
| cpu_tmr | input | TMR_W | CPU timer, two's complement |
| take | output | 1 | One-cycle strobe for a selected condition |
| int_code | output | 16 | Interruption code of the last take |
| orig_field | output | 16 | Originating-address field of the last take |
| int_parm | output | PARM_W | Parameter word of the last take |

## Verification
Every result is due one clock after the edge that samples `eval_req`. This applies to the strobe, all three fields and the clearing of the consumed condition. A set pulse sampled at an edge can be won by a request at the next edge. Inputs change only at falling edges. After every rising edge, the bench compares the outputs at the following falling edge against a behavioural model that advances once per edge. Directed checks then pin literal codes, CPU numbers and prefixed parameters at those same sample points. They also cover the boundary cases: equal comparator, a set pulse landing together with a take, and an empty vector behind a set flag.

// File: rtl/ext_sel_pkg.sv
package ext_sel_pkg;
  localparam int NSRC  = 8;
  localparam int SRC_W = 3;

  // Index order is the selection priority: lower index wins.
  typedef enum logic [SRC_W-1:0] {
    SRC_KEY   = 3'd0,
    SRC_MALF  = 3'd1,
    SRC_EMER  = 3'd2,
    SRC_XCALL = 3'd3,
    SRC_CLKC  = 3'd4,
    SRC_CPUT  = 3'd5,
    SRC_ITMR  = 3'd6,
    SRC_SVC   = 3'd7
  } src_e;
endpackage

// File: rtl/ext_lowest_bit.sv
module ext_lowest_bit #(
  parameter int N = 16,
  parameter int W = 4
) (
  input  logic [N-1:0] vec,
  output logic [W-1:0] idx,
  output logic         any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = W'(i);
    end
  end

  assign any = |vec;
endmodule

// File: rtl/ext_cpu_vec.sv
module ext_cpu_vec #(
  parameter int N = 16,
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set,
  input  logic [N-1:0] set_vec,
  input  logic         take,
  output logic         flag,
  output logic         empty,
  output logic [W-1:0] idx
);
  logic [N-1:0] vec_q;
  logic         flag_q;
  logic         any;
  logic         more;
  logic [N-1:0] clr_mask;

  ext_lowest_bit #(.N(N), .W(W)) u_low (
    .vec (vec_q),
    .idx (idx),
    .any (any)
  );

  // Another bit remains once the lowest one is removed.
  assign more = |(vec_q & (vec_q - N'(1)));

  always_comb begin
    clr_mask = '0;
    if (take && any) clr_mask[idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      vec_q <= (vec_q & ~clr_mask) | (set ? set_vec : '0);
      if (set)       flag_q <= 1'b1;
      else if (take) flag_q <= more;
    end
  end

  assign flag  = flag_q;
  assign empty = !any;

  AST_VEC_FLAG_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(take) && !$past(set)) |-> (flag_q == (|vec_q))); // R4
  AST_VEC_BIT_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(take && any) && !$past(set)) |-> !vec_q[$past(idx)]); // R4
endmodule

// File: rtl/ext_svc_latch.sv
module ext_svc_latch #(
  parameter int PARM_W  = 32,
  parameter int PFX_LSB = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set,
  input  logic [PARM_W-1:0] set_parm,
  input  logic              set_is_addr,
  input  logic              take,
  input  logic [PARM_W-1:0] prefix,
  output logic              pend,
  output logic [PARM_W-1:0] out_parm
);
  localparam logic [PARM_W-1:0] LOW_MASK  = (PARM_W'(1) << PFX_LSB) - PARM_W'(1);
  localparam logic [PARM_W-1:0] PAGE_MASK = ~LOW_MASK;

  logic              pend_q;
  logic              addr_q;
  logic [PARM_W-1:0] parm_q;
  logic [PARM_W-1:0] page_p;

  assign page_p = prefix & PAGE_MASK;

  always_comb begin
    out_parm = parm_q;
    if (addr_q) begin
      if ((parm_q & PAGE_MASK) == '0)
        out_parm = page_p | (parm_q & LOW_MASK);
      else if ((parm_q & PAGE_MASK) == page_p)
        out_parm = parm_q & LOW_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      addr_q <= 1'b0;
      parm_q <= '0;
    end else if (set) begin
      pend_q <= 1'b1;
      addr_q <= set_is_addr;
      parm_q <= set_parm;
    end else if (take) begin
      pend_q <= 1'b0;
      addr_q <= 1'b0;
      parm_q <= '0;
    end
  end

  assign pend = pend_q;

  AST_SVC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(take) && !$past(set)) |-> (!pend_q && parm_q == '0)); // R9
endmodule

// File: rtl/ext_int_selector.sv
module ext_int_selector
  import ext_sel_pkg::*;
#(
  parameter int          NCPU       = 16,
  parameter int          TOD_W      = 64,
  parameter int          TMR_W      = 64,
  parameter int          PARM_W     = 32,
  parameter int          PFX_LSB    = 13,
  parameter logic [15:0] CODE_KEY   = 16'h0040,
  parameter logic [15:0] CODE_MALF  = 16'h1200,
  parameter logic [15:0] CODE_EMER  = 16'h1201,
  parameter logic [15:0] CODE_XCALL = 16'h1202,
  parameter logic [15:0] CODE_CLKC  = 16'h1004,
  parameter logic [15:0] CODE_CPUT  = 16'h1005,
  parameter logic [15:0] CODE_ITMR  = 16'h0080,
  parameter logic [15:0] CODE_SVC   = 16'h2401
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_en,
  input  logic [NSRC-1:0]   src_en,
  input  logic              eval_req,
  input  logic              key_set,
  input  logic              malf_set,
  input  logic [NCPU-1:0]   malf_vec,
  input  logic              emer_set,
  input  logic [NCPU-1:0]   emer_vec,
  input  logic              xcall_set,
  input  logic [15:0]       xcall_cpu,
  input  logic              itmr_set,
  input  logic              svc_set,
  input  logic [PARM_W-1:0] svc_parm,
  input  logic              svc_is_addr,
  input  logic [PARM_W-1:0] prefix,
  input  logic [TOD_W-1:0]  tod,
  input  logic [TOD_W-1:0]  clkc,
  input  logic [TMR_W-1:0]  cpu_tmr,
  output logic              take,
  output logic [15:0]       int_code,
  output logic [15:0]       orig_field,
  output logic [PARM_W-1:0] int_parm
);
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1;

  // Latched single-bit conditions.
  logic        key_q, xc_q, it_q;
  logic [15:0] xc_ad_q;

  // Per-CPU vector sources: index 0 malfunction alert, 1 emergency signal.
  logic [1:0]       vset, vtake, vflag, vempty;
  logic [NCPU-1:0]  vin  [2];
  logic [CPU_W-1:0] vidx [2];

  assign vset   = {emer_set, malf_set};
  assign vin[0] = malf_vec;
  assign vin[1] = emer_vec;

  for (genvar g = 0; g < 2; g++) begin : g_vec
    ext_cpu_vec #(.N(NCPU), .W(CPU_W)) u_vec (
      .clk     (clk),
      .rst_n   (rst_n),
      .set     (vset[g]),
      .set_vec (vin[g]),
      .take    (vtake[g]),
      .flag    (vflag[g]),
      .empty   (vempty[g]),
      .idx     (vidx[g])
    );
  end

  logic              svc_pend, svc_take;
  logic [PARM_W-1:0] svc_out;

  ext_svc_latch #(.PARM_W(PARM_W), .PFX_LSB(PFX_LSB)) u_svc (
    .clk         (clk),
    .rst_n       (rst_n),
    .set         (svc_set),
    .set_parm    (svc_parm),
    .set_is_addr (svc_is_addr),
    .take        (svc_take),
    .prefix      (prefix),
    .pend        (svc_pend),
    .out_parm    (svc_out)
  );

  // Comparison conditions, evaluated every cycle.
  logic clkc_hit, cput_neg;
  assign clkc_hit = tod > clkc;
  assign cput_neg = cpu_tmr[TMR_W-1];

  logic [NSRC-1:0] pend, elig;
  logic [SRC_W-1:0] win_idx;
  logic             win_any;
  src_e             win;

  assign pend = {svc_pend, it_q, cput_neg, clkc_hit, xc_q, vflag[1], vflag[0], key_q};
  assign elig = pend & src_en;

  ext_lowest_bit #(.N(NSRC), .W(SRC_W)) u_prio (
    .vec (elig),
    .idx (win_idx),
    .any (win_any)
  );
  assign win = src_e'(win_idx);

  logic fire, empty_hit, do_take;
  assign fire      = eval_req && ext_en && win_any;
  assign empty_hit = (win == SRC_MALF && vempty[0]) || (win == SRC_EMER && vempty[1]);
  assign do_take   = fire && !empty_hit;
  assign vtake[0]  = fire && win == SRC_MALF;
  assign vtake[1]  = fire && win == SRC_EMER;
  assign svc_take  = fire && win == SRC_SVC;

  logic [15:0]       code_n, orig_n;
  logic [PARM_W-1:0] parm_n;

  always_comb begin
    code_n = CODE_KEY;
    orig_n = '0;
    parm_n = '0;
    case (win)
      SRC_KEY:   code_n = CODE_KEY;
      SRC_MALF:  begin code_n = CODE_MALF;  orig_n = 16'(vidx[0]); end
      SRC_EMER:  begin code_n = CODE_EMER;  orig_n = 16'(vidx[1]); end
      SRC_XCALL: begin code_n = CODE_XCALL; orig_n = xc_ad_q;      end
      SRC_CLKC:  code_n = CODE_CLKC;
      SRC_CPUT:  code_n = CODE_CPUT;
      SRC_ITMR:  code_n = CODE_ITMR;
      SRC_SVC:   begin code_n = CODE_SVC;   parm_n = svc_out;      end
      default:   code_n = CODE_KEY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q   <= 1'b0;
      xc_q    <= 1'b0;
      xc_ad_q <= '0;
      it_q    <= 1'b0;
    end else begin
      if (key_set)                          key_q <= 1'b1;
      else if (fire && win == SRC_KEY)      key_q <= 1'b0;
      if (xcall_set) begin
        xc_q    <= 1'b1;
        xc_ad_q <= xcall_cpu;
      end else if (fire && win == SRC_XCALL) begin
        xc_q    <= 1'b0;
      end
      if (itmr_set)                         it_q <= 1'b1;
      else if (fire && win == SRC_ITMR)     it_q <= 1'b0;
    end
  end

  logic              take_q;
  logic [15:0]       code_q, orig_q;
  logic [PARM_W-1:0] parm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      code_q <= '0;
      orig_q <= '0;
      parm_q <= '0;
    end else begin
      take_q <= do_take;
      if (do_take) begin
        code_q <= code_n;
        orig_q <= orig_n;
        parm_q <= parm_n;
      end
    end
  end

  assign take       = take_q;
  assign int_code   = code_q;
  assign orig_field = orig_q;
  assign int_parm   = parm_q;

  AST_TAKE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> $past(eval_req && ext_en)); // R11
  AST_CLKC_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
    (take_q && code_q == CODE_CLKC) |-> $past(tod > clkc)); // R6
  AST_KEY_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fire && win == SRC_KEY) && !$past(key_set)) |-> !key_q); // R3
  AST_KEY_MASK_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
    (take_q && code_q == CODE_KEY) |-> $past(src_en[0])); // R10
  AST_ORIG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (take_q && (code_q == CODE_KEY || code_q == CODE_ITMR || code_q == CODE_SVC))
      |-> orig_q == 16'h0000); // R8
endmodule

// File: tb/ext_int_selector_tb.sv
`timescale 1ns/1ps
module ext_int_selector_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_en = 1'b1;
  logic [7:0]  src_en = 8'hFF;
  logic        eval_req = 1'b0;
  logic        key_set = 1'b0, malf_set = 1'b0, emer_set = 1'b0;
  logic [15:0] malf_vec = '0, emer_vec = '0;
  logic        xcall_set = 1'b0;
  logic [15:0] xcall_cpu = '0;
  logic        itmr_set = 1'b0, svc_set = 1'b0, svc_is_addr = 1'b0;
  logic [31:0] svc_parm = '0, prefix = '0;
  logic [63:0] tod = '0, clkc = '0, cpu_tmr = '0;
  logic        take;
  logic [15:0] int_code, orig_field;
  logic [31:0] int_parm;

  always #2 clk = ~clk;

  ext_int_selector dut_i (
    .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .src_en(src_en), .eval_req(eval_req),
    .key_set(key_set), .malf_set(malf_set), .malf_vec(malf_vec),
    .emer_set(emer_set), .emer_vec(emer_vec), .xcall_set(xcall_set), .xcall_cpu(xcall_cpu),
    .itmr_set(itmr_set), .svc_set(svc_set), .svc_parm(svc_parm), .svc_is_addr(svc_is_addr),
    .prefix(prefix), .tod(tod), .clkc(clkc), .cpu_tmr(cpu_tmr),
    .take(take), .int_code(int_code), .orig_field(orig_field), .int_parm(int_parm)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  // Behavioural reference state.
  logic        m_key = 0, m_mf = 0, m_ef = 0, m_xc = 0, m_it = 0, m_sv = 0, m_sa = 0;
  logic [15:0] m_mv = 0, m_ev = 0, m_xa = 0;
  logic [31:0] m_sp = 0;
  logic        e_take = 0;
  logic [15:0] e_code = 0, e_orig = 0;
  logic [31:0] e_parm = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drain(inout logic [15:0] v, inout logic f, input logic [15:0] code,
                       output logic t, output logic [15:0] c, output logic [15:0] o);
    int pos = -1;
    t = 0; c = 0; o = 0;
    for (int j = 0; j < 16; j++) if (v[j] && pos < 0) pos = j;
    if (pos < 0) begin
      f = 0;
    end else begin
      v[pos] = 1'b0;
      f = (v != 16'h0);
      t = 1; c = code; o = 16'(pos);
    end
  endtask

  task automatic model_edge();
    logic [7:0]  p;
    logic        t;
    logic [15:0] c, o;
    logic [31:0] pr;
    int w = -1;
    t = 0; c = 0; o = 0; pr = 0;
    if (eval_req && ext_en) begin
      p = {m_sv, m_it, cpu_tmr[63], (tod > clkc), m_xc, m_ef, m_mf, m_key} & src_en;
      for (int i = 0; i < 8; i++) if (p[i] && w < 0) w = i;
      case (w)
        0: begin t = 1; c = 16'h0040; m_key = 0; end
        1: drain(m_mv, m_mf, 16'h1200, t, c, o);
        2: drain(m_ev, m_ef, 16'h1201, t, c, o);
        3: begin t = 1; c = 16'h1202; o = m_xa; m_xc = 0; end
        4: begin t = 1; c = 16'h1004; end
        5: begin t = 1; c = 16'h1005; end
        6: begin t = 1; c = 16'h0080; m_it = 0; end
        7: begin
          t = 1; c = 16'h2401; pr = m_sp;
          if (m_sa) begin
            if (m_sp[31:13] == 19'h0) pr = {prefix[31:13], m_sp[12:0]};
            else if (m_sp[31:13] == prefix[31:13]) pr = {19'h0, m_sp[12:0]};
          end
          m_sv = 0; m_sp = 0; m_sa = 0;
        end
        default: t = 0;
      endcase
    end
    if (key_set)   m_key = 1;
    if (malf_set)  begin m_mv = m_mv | malf_vec; m_mf = 1; end
    if (emer_set)  begin m_ev = m_ev | emer_vec; m_ef = 1; end
    if (xcall_set) begin m_xc = 1; m_xa = xcall_cpu; end
    if (itmr_set)  m_it = 1;
    if (svc_set)   begin m_sv = 1; m_sp = svc_parm; m_sa = svc_is_addr; end
    e_take = t;
    if (t) begin e_code = c; e_orig = o; e_parm = pr; end
  endtask

  // One clock: model advances with the edge, outputs sampled at the falling edge.
  task automatic step();
    model_edge();
    @(posedge clk);
    @(negedge clk);
    chk("R12 take vs model", 64'(take), 64'(e_take));
    chk("R2 code vs model", 64'(int_code), 64'(e_code));
    chk("R8 orig vs model", 64'(orig_field), 64'(e_orig));
    chk("R9 parm vs model", 64'(int_parm), 64'(e_parm));
    eval_req = 0; key_set = 0; malf_set = 0; emer_set = 0;
    xcall_set = 0; itmr_set = 0; svc_set = 0; svc_is_addr = 0;
    malf_vec = 0; emer_vec = 0;
  endtask

  task automatic ev(); eval_req = 1; step(); endtask

  task automatic want(input string tag, input logic [15:0] c, input logic [15:0] o,
                      input logic [31:0] p);
    chk(tag, 64'(take), 64'd1);
    chk(tag, 64'(int_code), 64'(c));
    chk(tag, 64'(orig_field), 64'(o));
    chk(tag, 64'(int_parm), 64'(p));
  endtask

  task automatic idle(input string tag);
    chk(tag, 64'(take), 64'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL R12 watchdog: actual %0d cycles expected fewer than 20000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset take", 64'(take), 64'd0);
    chk("R1 reset code", 64'(int_code), 64'd0);
    chk("R1 reset parm", 64'(int_parm), 64'd0);
    rst_n = 1;
    ev(); idle("R1 nothing pending");

    // Several sources at once, drained in priority order.
    key_set = 1; malf_set = 1; malf_vec = 16'h0024; xcall_set = 1; xcall_cpu = 16'h0007;
    itmr_set = 1; svc_set = 1; svc_parm = 32'h0000_0123;
    step(); idle("R3 set without request");
    ev(); want("R2 key first", 16'h0040, 16'h0, 32'h0);
    ev(); want("R4 malfunction lowest cpu", 16'h1200, 16'd2, 32'h0);
    ev(); want("R4 malfunction next cpu", 16'h1200, 16'd5, 32'h0);
    ev(); want("R8 external call address", 16'h1202, 16'd7, 32'h0);
    ev(); want("R8 interval timer orig zero", 16'h0080, 16'h0, 32'h0);
    ev(); want("R9 service plain parm", 16'h2401, 16'h0, 32'h0000_0123);
    ev(); idle("R3 all consumed");
    step(); idle("R12 strobe one cycle");
    chk("R12 code held", 64'(int_code), 64'h2401);

    // Emergency beats external call.
    emer_set = 1; emer_vec = 16'h0200; xcall_set = 1; xcall_cpu = 16'h0003;
    step();
    ev(); want("R2 emergency over external call", 16'h1201, 16'd9, 32'h0);
    ev(); want("R3 external call kept", 16'h1202, 16'd3, 32'h0);

    // Summary flag with empty vector.
    emer_set = 1; emer_vec = 16'h0; itmr_set = 1;
    step();
    ev(); idle("R5 empty vector no take");
    ev(); want("R5 flag dropped", 16'h0080, 16'h0, 32'h0);

    // Clock comparator.
    tod = 64'd100; clkc = 64'd100;
    ev(); idle("R6 equal not taken");
    tod = 64'd101;
    ev(); want("R6 greater taken", 16'h1004, 16'h0, 32'h0);
    ev(); want("R6 level stays", 16'h1004, 16'h0, 32'h0);
    tod = 64'd0; clkc = 64'd0;

    // CPU timer.
    cpu_tmr = 64'hFFFF_FFFF_FFFF_FFFF;
    ev(); want("R7 negative timer", 16'h1005, 16'h0, 32'h0);
    cpu_tmr = 64'd0;
    ev(); idle("R7 zero timer");

    // Per-source mask.
    key_set = 1; step();
    src_en = 8'hFE;
    ev(); idle("R10 masked key");
    src_en = 8'hFF;
    ev(); want("R10 key after unmask", 16'h0040, 16'h0, 32'h0);

    // Global enable.
    itmr_set = 1; step();
    ext_en = 0;
    ev(); idle("R11 disabled");
    ext_en = 1;
    ev(); want("R11 kept while disabled", 16'h0080, 16'h0, 32'h0);

    // Set and take in the same cycle.
    itmr_set = 1; step();
    itmr_set = 1; ev(); want("R12 take with set", 16'h0080, 16'h0, 32'h0);
    ev(); want("R12 set wins", 16'h0080, 16'h0, 32'h0);

    // Prefixing.
    prefix = 32'h0004_0000;
    svc_set = 1; svc_is_addr = 1; svc_parm = 32'h0000_0123; step();
    ev(); want("R9 page zero to prefix", 16'h2401, 16'h0, 32'h0004_0123);
    svc_set = 1; svc_is_addr = 1; svc_parm = 32'h0004_0456; step();
    ev(); want("R9 prefix page to zero", 16'h2401, 16'h0, 32'h0000_0456);
    svc_set = 1; svc_is_addr = 1; svc_parm = 32'h0010_0008; step();
    ev(); want("R9 other page unchanged", 16'h2401, 16'h0, 32'h0010_0008);
    svc_set = 1; svc_is_addr = 0; svc_parm = 32'h0004_0456; step();
    ev(); want("R9 not an address", 16'h2401, 16'h0, 32'h0004_0456);
    ev(); idle("R9 pending cleared");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule